// File: doc/BRIEF.md
# All-Digital Times-32 Clock Multiplier

This block takes a slow, free-running reference in the audio range, about 39 kHz to 50 kHz, and produces a clock at exactly 32 times its rate. Everything runs from one fixed 50 MHz system clock. There is no analog oscillator. A 32-bit phase accumulator acts as the oscillator, and the top bit of the accumulator is the generated clock. A 5-bit counter divides that clock by 32. A phase/frequency detector compares the counter's carry with the synchronized reference, and a proportional-plus-integral filter turns the measured error into the accumulator step.

The reference is an asynchronous pin. The generated clock appears two ways: as a square wave, and as a one-cycle enable pulse on each of its rising edges. Downstream logic is meant to use the pulse as a clock enable inside the system clock domain. A 2-bit gain setting selects the loop response, from fast and lively to slow and steady. A lock flag reports when the loop has settled. The block has no streaming data path, so every pin is a plain control or status level.

Top module: `cmul32`

## Requirements
- R1: After reset the lock flag is low, the step is the 1.4 MHz center value and the integrator is zero. With no reference edges the oscillator free-runs at 1.4 MHz, which is 140 (±1) enable pulses in 5000 system cycles.
- R2: `out_tick` is a single-cycle pulse issued once for every rising edge of `out_clk`. `out_clk` stays high in the cycle after the pulse.
- R3: Once locked to a 45 kHz reference, the block gives 512 (±1) enable pulses over 16 reference periods, which is within 0.2% of 32 times the reference.
- R4: The lock flag rises only after 16 consecutive detector samples whose magnitude is at most 4 system cycles. At gain setting 0 it rises within 80,000 cycles of a 45 kHz reference starting.
- R5: Any detector sample larger than 4 cycles in magnitude clears the lock flag in the next cycle. A step from 45 kHz to 47 kHz drops lock within 6000 cycles.
- R6: The loop follows a change in reference rate. After the step to 47 kHz it relocks and gives 256 (±1) pulses over 8 periods.
- R7: `gain_sel` value g sets the proportional shift to 15−g and the integral shift to 12−2g, so 0 is the fastest setting and 3 the slowest. At setting 3, a step down to 40 kHz still leaves at least 262 pulses over 8 periods, taken from the third period after the step.
- R8: The step is clamped to the range that corresponds to 1.2 MHz to 1.7 MHz, and the integrator saturates at ±(max−min step) instead of wrapping. With an 80 kHz reference the output settles at 1.7 MHz, which is 170 (±2) pulses in 5000 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Asynchronous reference clock, 39–50 kHz |
| gain_sel | input | 2 | Loop gain: 0 fastest to 3 slowest |
| out_clk | output | 1 | Generated clock: MSB of the phase accumulator |
| out_tick | output | 1 | One-cycle enable pulse on each rising edge of `out_clk` |
| locked | output | 1 | High while the loop is in lock |

## Verification
The bench first checks the free-running center rate. It then pulls the loop in from that rate and counts enable pulses between reference edges. A detector sign error or a bad filter shift would show up here as a count that never settles at 32 per period. A frequency step checks that lock is cleared at once and then regained. An out-of-range reference drives the step into its ceiling: a clamp or integrator that wrapped would give a very low or oscillating rate instead of 1.7 MHz. The slowest gain setting must still be running fast several periods after a downward step, which catches a gain decode that ignores `gain_sel`.

// File: rtl/cmul32_pkg.sv
package cmul32_pkg;

  // Width of a signed phase-error sample, in system cycles.
  localparam int ERR_W      = 16;
  // Guard bits added above the accumulator width for filter arithmetic.
  localparam int FILT_GUARD = 8;
  // Width of the gain selector.
  localparam int GAIN_W     = 2;

  typedef struct packed {
    logic                    vld;
    logic signed [ERR_W-1:0] val;
  } perr_t;

  // Phase step that makes an acc_w-bit accumulator toggle at f_hz.
  function automatic logic [63:0] hz_to_inc(longint unsigned f_hz,
                                            longint unsigned sys_hz,
                                            int unsigned     acc_w);
    return (64'(f_hz) << acc_w) / 64'(sys_hz);
  endfunction

endpackage

// File: rtl/cmul32_ref_sync.sv
module cmul32_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  // pipe[STAGES-1] is the synchronized level; pipe[STAGES] is its prior value.
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], async_in};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];

endmodule

// File: rtl/cmul32_osc.sv
module cmul32_osc #(
  parameter int ACC_W = 32,
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] inc,
  output logic             out_clk,
  output logic             out_tick,
  output logic             fb_pulse
);

  localparam int MSB = ACC_W - 1;

  logic [ACC_W-1:0] acc_q;
  logic             msb_q;
  logic [DIV_W-1:0] div_q;

  assign out_clk  = acc_q[MSB];
  assign out_tick = acc_q[MSB] & ~msb_q;
  // Divider carry: the tick that wraps the counter from all-ones to zero.
  assign fb_pulse = out_tick & (&div_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      msb_q <= 1'b0;
      div_q <= '0;
    end else begin
      acc_q <= acc_q + inc;
      msb_q <= acc_q[MSB];
      if (out_tick) div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/cmul32_pfd.sv
module cmul32_pfd
  import cmul32_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ref_rise,
  input  logic  fb_pulse,
  output perr_t err
);

  localparam int CNT_W = ERR_W - 1;

  logic             up_q, dn_q;
  logic [CNT_W-1:0] cnt_q, cnt_step;
  logic signed [ERR_W-1:0] lead_pos, lead_neg;
  logic             vld_q;
  logic signed [ERR_W-1:0] val_q;

  // Width counter saturates instead of wrapping, so a large frequency
  // gap reads as a large error rather than a small one.
  assign cnt_step = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
  assign lead_pos = $signed({1'b0, cnt_q});
  assign lead_neg = -lead_pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      cnt_q <= '0;
      vld_q <= 1'b0;
      val_q <= '0;
    end else begin
      vld_q <= 1'b0;
      unique case ({ref_rise, fb_pulse})
        2'b11: begin
          vld_q <= 1'b1;
          val_q <= up_q ? lead_pos : (dn_q ? lead_neg : '0);
          up_q  <= 1'b0;
          dn_q  <= 1'b0;
          cnt_q <= '0;
        end
        2'b10: begin
          if (dn_q) begin
            vld_q <= 1'b1;
            val_q <= lead_neg;
            dn_q  <= 1'b0;
            cnt_q <= '0;
          end else begin
            up_q  <= 1'b1;
            cnt_q <= up_q ? cnt_step : '0;
          end
        end
        2'b01: begin
          if (up_q) begin
            vld_q <= 1'b1;
            val_q <= lead_pos;
            up_q  <= 1'b0;
            cnt_q <= '0;
          end else begin
            dn_q  <= 1'b1;
            cnt_q <= dn_q ? cnt_step : '0;
          end
        end
        default: begin
          if (up_q || dn_q) cnt_q <= cnt_step;
        end
      endcase
    end
  end

  assign err.vld = vld_q;
  assign err.val = val_q;

endmodule

// File: rtl/cmul32_loop.sv
module cmul32_loop
  import cmul32_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int F_SYS_HZ = 50_000_000,
  parameter int F_MIN_HZ = 1_200_000,
  parameter int F_CTR_HZ = 1_400_000,
  parameter int F_MAX_HZ = 1_700_000,
  parameter int KP_BASE  = 15,
  parameter int KI_BASE  = 12,
  parameter int LOCK_THR = 4,
  parameter int LOCK_N   = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  perr_t                               err,
  input  logic [GAIN_W-1:0]                   gain_sel,
  output logic [ACC_W-1:0]                    inc,
  output logic signed [ACC_W+FILT_GUARD-1:0]  integ,
  output logic                                locked
);

  localparam int W    = ACC_W + FILT_GUARD;
  localparam int LCW  = $clog2(LOCK_N);
  localparam int SH_W = 5;

  localparam logic [63:0] MIN_L  = hz_to_inc(F_MIN_HZ, F_SYS_HZ, ACC_W);
  localparam logic [63:0] CTR_L  = hz_to_inc(F_CTR_HZ, F_SYS_HZ, ACC_W);
  localparam logic [63:0] MAX_L  = hz_to_inc(F_MAX_HZ, F_SYS_HZ, ACC_W);
  localparam logic [63:0] SPAN_L = MAX_L - MIN_L;

  localparam logic signed [W-1:0] MIN_S  = $signed(W'(MIN_L));
  localparam logic signed [W-1:0] CTR_S  = $signed(W'(CTR_L));
  localparam logic signed [W-1:0] MAX_S  = $signed(W'(MAX_L));
  localparam logic signed [W-1:0] LIM_S  = $signed(W'(SPAN_L));
  localparam logic signed [W-1:0] THR_S  = $signed(W'(LOCK_THR));
  localparam logic [ACC_W-1:0]    CTR_U  = CTR_L[ACC_W-1:0];

  logic [SH_W-1:0]      kp_sh, ki_sh;
  logic signed [W-1:0]  e_w, p_term, i_step, i_sum, i_next, raw;
  logic [ACC_W-1:0]     inc_next, inc_q;
  logic signed [W-1:0]  integ_q;
  logic [LCW-1:0]       good_cnt;
  logic                 small_err, lock_q;

  // Gain decode: a larger setting shifts less, giving a slower loop.
  assign kp_sh = SH_W'(KP_BASE) - {{(SH_W-GAIN_W){1'b0}}, gain_sel};
  assign ki_sh = SH_W'(KI_BASE) - {{(SH_W-GAIN_W-1){1'b0}}, gain_sel, 1'b0};

  assign e_w    = {{(W-ERR_W){err.val[ERR_W-1]}}, err.val};
  assign p_term = e_w <<< kp_sh;
  assign i_step = e_w <<< ki_sh;
  assign i_sum  = integ_q + i_step;

  // Saturating integrator.
  always_comb begin
    if (i_sum > LIM_S)       i_next = LIM_S;
    else if (i_sum < -LIM_S) i_next = -LIM_S;
    else                     i_next = i_sum;
  end

  assign raw = CTR_S + p_term + i_next;

  // Clamp the step to the allowed output-frequency window.
  always_comb begin
    if (raw > MAX_S)      inc_next = MAX_L[ACC_W-1:0];
    else if (raw < MIN_S) inc_next = MIN_L[ACC_W-1:0];
    else                  inc_next = raw[ACC_W-1:0];
  end

  assign small_err = (e_w <= THR_S) && (e_w >= -THR_S);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inc_q    <= CTR_U;
      integ_q  <= '0;
      good_cnt <= '0;
      lock_q   <= 1'b0;
    end else if (err.vld) begin
      inc_q   <= inc_next;
      integ_q <= i_next;
      if (small_err) begin
        if (!lock_q) begin
          if (good_cnt == LCW'(LOCK_N - 1)) lock_q   <= 1'b1;
          else                              good_cnt <= good_cnt + 1'b1;
        end
      end else begin
        good_cnt <= '0;
        lock_q   <= 1'b0;
      end
    end
  end

  assign inc    = inc_q;
  assign integ  = integ_q;
  assign locked = lock_q;

endmodule

// File: rtl/cmul32.sv
module cmul32
  import cmul32_pkg::*;
#(
  parameter int ACC_W       = 32,
  parameter int DIV_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int F_SYS_HZ    = 50_000_000,
  parameter int F_MIN_HZ    = 1_200_000,
  parameter int F_CTR_HZ    = 1_400_000,
  parameter int F_MAX_HZ    = 1_700_000,
  parameter int KP_BASE     = 15,
  parameter int KI_BASE     = 12,
  parameter int LOCK_THR    = 4,
  parameter int LOCK_N      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic [GAIN_W-1:0] gain_sel,
  output logic              out_clk,
  output logic              out_tick,
  output logic              locked
);

  localparam int W = ACC_W + FILT_GUARD;

  logic                ref_rise;
  logic                fb_pulse;
  perr_t               pfd_err;
  logic [ACC_W-1:0]    inc_w;
  logic signed [W-1:0] integ_w;

  cmul32_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ref_in),
    .rise     (ref_rise)
  );

  cmul32_osc #(.ACC_W(ACC_W), .DIV_W(DIV_W)) u_osc (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (inc_w),
    .out_clk  (out_clk),
    .out_tick (out_tick),
    .fb_pulse (fb_pulse)
  );

  cmul32_pfd u_pfd (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_rise (ref_rise),
    .fb_pulse (fb_pulse),
    .err      (pfd_err)
  );

  cmul32_loop #(
    .ACC_W    (ACC_W),
    .F_SYS_HZ (F_SYS_HZ),
    .F_MIN_HZ (F_MIN_HZ),
    .F_CTR_HZ (F_CTR_HZ),
    .F_MAX_HZ (F_MAX_HZ),
    .KP_BASE  (KP_BASE),
    .KI_BASE  (KI_BASE),
    .LOCK_THR (LOCK_THR),
    .LOCK_N   (LOCK_N)
  ) u_loop (
    .clk      (clk),
    .rst_n    (rst_n),
    .err      (pfd_err),
    .gain_sel (gain_sel),
    .inc      (inc_w),
    .integ    (integ_w),
    .locked   (locked)
  );

endmodule

// File: rtl/cmul32_chk.sv
module cmul32_chk
  import cmul32_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int F_SYS_HZ = 50_000_000,
  parameter int F_MIN_HZ = 1_200_000,
  parameter int F_CTR_HZ = 1_400_000,
  parameter int F_MAX_HZ = 1_700_000,
  parameter int LOCK_THR = 4
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               out_clk,
  input logic                               out_tick,
  input logic                               locked,
  input logic                               err_vld,
  input logic signed [ERR_W-1:0]            err_val,
  input logic [ACC_W-1:0]                   inc,
  input logic signed [ACC_W+FILT_GUARD-1:0] integ
);

  localparam int W = ACC_W + FILT_GUARD;
  localparam logic [63:0] MIN_L = hz_to_inc(F_MIN_HZ, F_SYS_HZ, ACC_W);
  localparam logic [63:0] CTR_L = hz_to_inc(F_CTR_HZ, F_SYS_HZ, ACC_W);
  localparam logic [63:0] MAX_L = hz_to_inc(F_MAX_HZ, F_SYS_HZ, ACC_W);
  localparam logic signed [W-1:0] LIM_S = $signed(W'(MAX_L - MIN_L));
  localparam logic signed [ERR_W-1:0] THR_E = ERR_W'(LOCK_THR);

  logic seen_err;

  always_ff @(posedge clk) begin
    if (!rst_n)       seen_err <= 1'b0;
    else if (err_vld) seen_err <= 1'b1;
  end

  // R1
  ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_err |-> inc == CTR_L[ACC_W-1:0]);

  // R2
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_tick |=> !out_tick);

  // R2
  tick_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_tick |=> out_clk);

  // R4
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(err_vld));

  // R5
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vld && (err_val > THR_E || err_val < -THR_E)) |=> !locked);

  // R8
  inc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc >= MIN_L[ACC_W-1:0] && inc <= MAX_L[ACC_W-1:0]);

  // R8
  integ_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    integ <= LIM_S && integ >= -LIM_S);

endmodule

bind cmul32 cmul32_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .out_clk  (out_clk),
  .out_tick (out_tick),
  .locked   (locked),
  .err_vld  (pfd_err.vld),
  .err_val  (pfd_err.val),
  .inc      (inc_w),
  .integ    (integ_w)
);

// File: tb/cmul32_tb_top.sv
module cmul32_tb_top;

  localparam int CLK_NS   = 20;
  localparam int WDOG_CYC = 195_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0;
  logic [1:0] gain_sel = 2'd0;
  logic       out_clk, out_tick, locked;

  int ref_half_ns = 0;
  int tick_total  = 0;
  int rise_total  = 0;
  int n_run       = 0;
  int n_fail      = 0;
  int mon_done    = 0;
  bit done        = 1'b0;
  logic clk_prev  = 1'b0;

  typedef struct {
    string tag;
    int    periods;
    int    lo;
    int    hi;
  } win_t;

  win_t sb_q[$];

  cmul32 dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_in   (ref_in),
    .gain_sel (gain_sel),
    .out_clk  (out_clk),
    .out_tick (out_tick),
    .locked   (locked)
  );

  always #(CLK_NS/2) clk = ~clk;

  // Reference generator: held low while the half period is zero.
  initial begin
    forever begin
      if (ref_half_ns == 0) begin
        ref_in = 1'b0;
        #100;
      end else begin
        #(ref_half_ns) ref_in = ~ref_in;
      end
    end
  end

  // Output observers, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_tick) tick_total++;
      if (out_clk && !clk_prev) rise_total++;
      clk_prev <= out_clk;
    end
  end

  task automatic check_range(string tag, int act, int lo, int hi);
    n_run++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d, expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // Scoreboard driver: queue an expected pulse count over a reference window.
  task automatic expect_window(string tag, int periods, int lo, int hi);
    int target;
    win_t it;
    it.tag = tag; it.periods = periods; it.lo = lo; it.hi = hi;
    target = mon_done + 1;
    sb_q.push_back(it);
    while (mon_done < target) @(negedge clk);
  endtask

  // Scoreboard monitor: pop an item and measure the design against it.
  initial begin
    forever begin
      win_t it;
      int start;
      while (sb_q.size() == 0) @(negedge clk);
      it = sb_q.pop_front();
      @(posedge ref_in);
      @(negedge clk);
      start = tick_total;
      repeat (it.periods) @(posedge ref_in);
      @(negedge clk);
      check_range(it.tag, tick_total - start, it.lo, it.hi);
      mon_done++;
    end
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout, expected completion");
    finish_run();
  end

  task automatic wait_lock(output int cyc, input int limit);
    cyc = 0;
    while (!locked && cyc < limit) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    int t0, r0, cyc;

    repeat (5) @(posedge clk);
    @(negedge clk);
    check_range("R1 locked low in reset", int'(locked), 0, 0);
    check_range("R1 no tick in reset", int'(out_tick), 0, 0);
    rst_n = 1'b1;

    // R1 free-running center rate; R2 one pulse per rising edge.
    @(negedge clk);
    t0 = tick_total; r0 = rise_total;
    repeat (5000) @(negedge clk);
    check_range("R1 free-run pulses", tick_total - t0, 139, 141);
    check_range("R2 pulses vs rising edges", (tick_total - t0) - (rise_total - r0), 0, 0);
    check_range("R1 unlocked without ref", int'(locked), 0, 0);

    // R4 pull-in at 45 kHz with the fastest gain.
    ref_half_ns = 11111;
    wait_lock(cyc, 80000);
    check_range("R4 lock time", cyc, 17000, 79999);

    // R3 output is 32x the reference.
    expect_window("R3 pulses over 16 periods", 16, 511, 513);
    check_range("R3 still locked", int'(locked), 1, 1);

    // R5 a frequency step clears lock.
    ref_half_ns = 10638;
    cyc = 0;
    while (locked && cyc < 6000) begin
      @(negedge clk);
      cyc++;
    end
    check_range("R5 lock drop cycles", cyc, 0, 5999);

    // R6 relock at 47 kHz.
    wait_lock(cyc, 70000);
    check_range("R6 relock", int'(locked), 1, 1);
    expect_window("R6 pulses over 8 periods", 8, 255, 257);

    // R7 slowest gain still far off after a downward step.
    gain_sel = 2'd3;
    ref_half_ns = 12500;
    repeat (2) @(posedge ref_in);
    expect_window("R7 slow loop pulses over 8 periods", 8, 262, 400);

    // R8 reference beyond range: step clamps at 1.7 MHz.
    gain_sel = 2'd0;
    ref_half_ns = 6250;
    repeat (20) @(posedge ref_in);
    @(negedge clk);
    t0 = tick_total;
    repeat (5000) @(negedge clk);
    check_range("R8 clamped pulses", tick_total - t0, 168, 172);

    finish_run();
  end

endmodule